// File: doc/BRIEF.md
# Multi-core global timer with per-core comparators

This block is a timer that up to four processor cores share. It has a single 64-bit up-counter and a programmable prescaler, and both are common to every core. Each core also has its own bank, made of a 64-bit comparator, a 32-bit reload step, three control bits, an event flag and an interrupt line. When the counter reaches a core's comparator, that core's flag is set. The comparator can then add its step to itself, which produces periodic events.

Software reaches the block through a plain 32-bit register port that has a 0x20-byte window. Every access carries a core number, and that number picks the bank that the banked registers refer to. A read is combinational and is valid in the cycle where `bus_sel` is high and `bus_wr` is low. A write takes effect at the next rising clock edge.

Top module: `gtimer_multicore`

## Requirements
- R1: While the run bit is set, the counter grows by one every (div + 1) clock cycles. The divide field sits in control bits 15:8. The first step comes div + 1 edges after the edge that sets the run bit.
- R2: While the run bit (control bit 0) is clear, the counter keeps its value, except when software writes it.
- R3: A write to counter offset 0x00 or 0x04 has no effect while the run bit is set.
- R4: The counter occupies offset 0x00 (low word) and 0x04 (high word). A core's comparator occupies 0x10 (low) and 0x14 (high). A write changes only the addressed 32-bit half.
- R5: When the run bit and the core's compare-enable bit (control bit 1) are both set and the counter is greater than or equal to that core's comparator, the core's flag is set on the next edge. No flag is set while the run bit is clear.
- R6: When a compare event occurs and the core's reload bit (control bit 3) is set, the comparator is increased by the core's step register (offset 0x18) on the same edge.
- R7: Line irq[i] is high exactly when core i's flag is set and its interrupt-enable bit (control bit 2) is set.
- R8: The flag reads at offset 0x0C, bit 0. Writing 1 to bit 0 clears it. Writing 0 leaves it as it is. A compare event in the same cycle wins over the clear.
- R9: A write to control offset 0x08 updates the run bit and the divide field, which are shared, and also the calling core's bits 3:1. A read returns the shared bits merged with the caller's banked bits, and every other bit reads as zero.
- R10: Reset sets the counter, the shared control, and every core's control, flag, comparator and step to zero.
- R11: A read of any offset not listed above, including offsets that are not word-aligned, returns zero. A write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| core_id | input | ID_W | Number of the core making the access |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| irq | output | NCORE | Interrupt line of each core |

## Verification
The checker module watches on every cycle that the counter never moves by more than one step, stays frozen while it is stopped, and ignores writes while it runs. It also watches that no flag rises while the timer is stopped, that no interrupt appears without its flag, and that unmapped reads return zero. Several behaviours are visible only in the bench scenarios, which check them against a behavioural model. These are the exact prescaler timing, the half-word loads, the periodic comparator reload, the write-one-to-clear rule, the merging of shared and banked control bits across different core numbers, and the state after a reset in the middle of a run.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 5;

   // register offsets
   localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h10;
   localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h14;
   localparam logic [ADDR_W-1:0] OFS_STEP   = 5'h18;

   // control bit positions
   localparam int B_RUN   = 0;
   localparam int B_CEN   = 1;
   localparam int B_AUTO  = 3;
   localparam int DIV_LSB = 8;

   // banked control bits, packed in the order of bits 3:1
   typedef struct packed {
      logic reload;
      logic irq_en;
      logic cmp_en;
   } bank_ctl_t;
endpackage

// File: rtl/gtm_prescale.sv
module gtm_prescale #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] phase;

   assign tick = run && (phase == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase <= '0;
      else if (!run||tick) phase <= '0;
      else                 phase <= phase + 1'b1;
   end
endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
   parameter int CNT_W = 64,
   parameter int HALF  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_lo,
   input  logic             load_hi,
   input  logic [HALF-1:0]  wdata,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
      else if (load_lo) cnt[HALF-1:0] <= wdata;
      else if (load_hi) cnt[CNT_W-1:HALF] <= wdata;
   end
endmodule

// File: rtl/gtm_core_bank.sv
module gtm_core_bank
   import gtm_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int HALF  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic             ctl_we,
   input  bank_ctl_t        ctl_wdata,
   input  logic             flag_we,
   input  logic             cmp_lo_we,
   input  logic             cmp_hi_we,
   input  logic             step_we,
   input  logic [HALF-1:0]  wdata,
   output bank_ctl_t        ctl,
   output logic             flag,
   output logic [CNT_W-1:0] cmp,
   output logic [HALF-1:0]  step,
   output logic             irq
);
   logic hit;

   assign hit = run && ctl.cmp_en && (cnt >= cmp);
   assign irq = flag && ctl.irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         flag <= 1'b0;
         cmp  <= '0;
         step <= '0;
      end else begin
         if (ctl_we) ctl <= ctl_wdata;

         if (hit)                    flag <= 1'b1;
         else if (flag_we&&wdata[0]) flag <= 1'b0;

         if (cmp_lo_we)               cmp[HALF-1:0]     <= wdata;
         else if (cmp_hi_we)          cmp[CNT_W-1:HALF] <= wdata;
         else if (hit && ctl.reload)  cmp <= cmp + CNT_W'(step);

         if (step_we) step <= wdata;
      end
   end
endmodule

// File: rtl/gtimer_multicore.sv
module gtimer_multicore
   import gtm_pkg::*;
#(
   parameter  int NCORE = 4,
   parameter  int DIV_W = 8,
   parameter  int CNT_W = 64,
   localparam int ID_W  = (NCORE > 1) ? $clog2(NCORE) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   input  logic [ID_W-1:0]    core_id,
   output logic [BUS_W-1:0]   bus_rdata,
   output logic [NCORE-1:0]   irq
);
   localparam int HALF = BUS_W;

   if (NCORE < 1 || NCORE > 4) begin : g_bad_ncore
      $error("NCORE must lie in 1..4");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (CNT_W != 2 * HALF) begin : g_bad_cnt
      $error("CNT_W must be twice the bus width");
   end

   logic             acc_w;
   logic             id_ok;
   logic             run;
   logic [DIV_W-1:0] div;
   logic             tick;
   logic [CNT_W-1:0] cnt;

   bank_ctl_t        ctl_v  [NCORE];
   logic [CNT_W-1:0] cmp_v  [NCORE];
   logic [HALF-1:0]  step_v [NCORE];
   logic [NCORE-1:0] flag_v;

   assign acc_w = bus_sel && bus_wr;

   // core number range check only where the id width allows holes
   if ((1 << ID_W) > NCORE) begin : g_idchk
      assign id_ok = (core_id < ID_W'(NCORE));
   end else begin : g_idall
      assign id_ok = 1'b1;
   end

   // shared control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         div <= '0;
      end else if (acc_w && bus_addr == OFS_CTRL) begin
         run <= bus_wdata[B_RUN];
         div <= bus_wdata[DIV_LSB +: DIV_W];
      end
   end

   gtm_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk (clk), .rst_n (rst_n), .run (run), .div (div), .tick (tick)
   );

   gtm_counter #(.CNT_W(CNT_W), .HALF(HALF)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load_lo (acc_w && !run && bus_addr == OFS_CNT_LO),
      .load_hi (acc_w && !run && bus_addr == OFS_CNT_HI),
      .wdata   (bus_wdata),
      .cnt     (cnt)
   );

   for (genvar g = 0; g < NCORE; g++) begin : g_bank
      logic mine;
      assign mine = acc_w && id_ok && (core_id == ID_W'(g));

      gtm_core_bank #(.CNT_W(CNT_W), .HALF(HALF)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run),
         .cnt       (cnt),
         .ctl_we    (mine && bus_addr == OFS_CTRL),
         .ctl_wdata (bank_ctl_t'(bus_wdata[B_AUTO:B_CEN])),
         .flag_we   (mine && bus_addr == OFS_STAT),
         .cmp_lo_we (mine && bus_addr == OFS_CMP_LO),
         .cmp_hi_we (mine && bus_addr == OFS_CMP_HI),
         .step_we   (mine && bus_addr == OFS_STEP),
         .wdata     (bus_wdata),
         .ctl       (ctl_v[g]),
         .flag      (flag_v[g]),
         .cmp       (cmp_v[g]),
         .step      (step_v[g]),
         .irq       (irq[g])
      );
   end

   // banked view of the calling core
   bank_ctl_t        s_ctl;
   logic             s_flag;
   logic [CNT_W-1:0] s_cmp;
   logic [HALF-1:0]  s_step;
   logic [BUS_W-1:0] ctrl_word;

   always_comb begin
      s_ctl  = '0;
      s_flag = 1'b0;
      s_cmp  = '0;
      s_step = '0;
      if (id_ok) begin
         s_ctl  = ctl_v[core_id];
         s_flag = flag_v[core_id];
         s_cmp  = cmp_v[core_id];
         s_step = step_v[core_id];
      end
   end

   always_comb begin
      ctrl_word                    = '0;
      ctrl_word[B_RUN]             = run;
      ctrl_word[B_AUTO:B_CEN]      = s_ctl;
      ctrl_word[DIV_LSB +: DIV_W]  = div;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            OFS_CNT_LO: bus_rdata = cnt[HALF-1:0];
            OFS_CNT_HI: bus_rdata = cnt[CNT_W-1:HALF];
            OFS_CTRL:   bus_rdata = ctrl_word;
            OFS_STAT:   bus_rdata = {{(BUS_W-1){1'b0}}, s_flag};
            OFS_CMP_LO: bus_rdata = s_cmp[HALF-1:0];
            OFS_CMP_HI: bus_rdata = s_cmp[CNT_W-1:HALF];
            OFS_STEP:   bus_rdata = s_step;
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gtm_chk.sv
module gtm_chk
   import gtm_pkg::*;
#(
   parameter int NCORE = 4,
   parameter int CNT_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [NCORE-1:0]  irq,
   input logic              run,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [NCORE-1:0]  flag_v
);
   logic cnt_wr;
   assign cnt_wr = bus_sel && bus_wr &&
                   (bus_addr == OFS_CNT_LO || bus_addr == OFS_CNT_HI);

   AST_CNT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R1

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt)); // R2

   AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && cnt_wr) |=> $stable(cnt)); // R3

   AST_NO_IDLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ((flag_v & ~$past(flag_v)) == '0)); // R5

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~flag_v) == '0); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (bus_addr > OFS_STEP || bus_addr[1:0] != 2'b00))
      |-> bus_rdata == '0); // R11
endmodule

bind gtimer_multicore gtm_chk #(.NCORE(NCORE), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .run       (run),
   .tick      (tick),
   .cnt       (cnt),
   .flag_v    (flag_v)
);

// File: tb/gtimer_multicore_tb.sv
module gtimer_multicore_tb;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [1:0]  cid = '0;
   logic [31:0] rdata;
   logic [NC-1:0] irq;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;
   string cur_req = "R10";

   always #5 clk = ~clk;

   gtimer_multicore #(.NCORE(NC)) u_dut (
      .clk (clk), .rst_n (rst_n), .bus_sel (sel), .bus_wr (wr),
      .bus_addr (addr), .bus_wdata (wdata), .core_id (cid),
      .bus_rdata (rdata), .irq (irq)
   );

   // ---------------- behavioural reference ----------------
   logic [63:0] m_cnt = '0;
   logic [7:0]  m_div = '0;
   int          m_phase = 0;
   logic        m_run = 1'b0;
   logic [63:0] m_cmp  [NC];
   logic [31:0] m_step [NC];
   logic        m_cen  [NC];
   logic        m_ien  [NC];
   logic        m_rel  [NC];
   logic        m_flag [NC];

   initial for (int i = 0; i < NC; i++) begin
      m_cmp[i] = '0; m_step[i] = '0; m_cen[i] = 0;
      m_ien[i] = 0; m_rel[i] = 0; m_flag[i] = 0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = '0; m_div = '0; m_phase = 0; m_run = 0;
         for (int i = 0; i < NC; i++) begin
            m_cmp[i] = '0; m_step[i] = '0; m_cen[i] = 0;
            m_ien[i] = 0; m_rel[i] = 0; m_flag[i] = 0;
         end
      end else begin
         automatic bit ws = sel && wr;
         automatic bit tk = m_run && (m_phase == int'(m_div));
         for (int i = 0; i < NC; i++) begin
            automatic bit ev = m_run && m_cen[i] && (m_cnt >= m_cmp[i]);
            automatic bit me = ws && (int'(cid) == i);
            if (ev) m_flag[i] = 1;
            else if (me && addr == 5'h0C && wdata[0]) m_flag[i] = 0;
            if (me && addr == 5'h10) m_cmp[i][31:0] = wdata;
            else if (me && addr == 5'h14) m_cmp[i][63:32] = wdata;
            else if (ev && m_rel[i]) m_cmp[i] = m_cmp[i] + {32'h0, m_step[i]};
            if (me && addr == 5'h18) m_step[i] = wdata;
            if (me && addr == 5'h08) begin
               m_cen[i] = wdata[1]; m_ien[i] = wdata[2]; m_rel[i] = wdata[3];
            end
         end
         if (tk) m_cnt = m_cnt + 1;
         else if (ws && !m_run && addr == 5'h00) m_cnt[31:0] = wdata;
         else if (ws && !m_run && addr == 5'h04) m_cnt[63:32] = wdata;
         m_phase = !m_run ? 0 : (tk ? 0 : m_phase + 1);
         if (ws && addr == 5'h08) begin
            m_run = wdata[0]; m_div = wdata[15:8];
         end
      end
   end

   function automatic logic [31:0] m_read(logic [4:0] a, int id);
      case (a)
         5'h00: return m_cnt[31:0];
         5'h04: return m_cnt[63:32];
         5'h08: return {16'h0, m_div, 4'h0, m_rel[id], m_ien[id], m_cen[id], m_run};
         5'h0C: return {31'h0, m_flag[id]};
         5'h10: return m_cmp[id][31:0];
         5'h14: return m_cmp[id][63:32];
         5'h18: return m_step[id];
         default: return 32'h0;
      endcase
   endfunction

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      logic [NC-1:0] ei;
      for (int i = 0; i < NC; i++) ei[i] = m_flag[i] & m_ien[i];
      compared++;
      if (irq !== ei) begin
         mismatched++;
         $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, ei);
      end
      if (sel && !wr) begin
         automatic logic [31:0] er = m_read(addr, int'(cid));
         compared++;
         if (rdata !== er) begin
            mismatched++;
            $display("FAIL %s read @%h core %0d actual=%h expected=%h",
                     cur_req, addr, cid, rdata, er);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         mismatched++;
         $display("FAIL watchdog actual=%0d cycles expected<=100000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input int id);
      @(posedge clk); #1;
      sel = 1; wr = 1; addr = a; wdata = d; cid = 2'(id);
      @(posedge clk); #1;
      sel = 0; wr = 0;
   endtask

   task automatic bus_read(input logic [4:0] a, input int id, output logic [31:0] v);
      @(posedge clk); #1;
      sel = 1; wr = 0; addr = a; cid = 2'(id);
      @(negedge clk);
      v = rdata;
      @(posedge clk); #1;
      sel = 0;
   endtask

   task automatic read_chk(input logic [4:0] a, input int id, input logic [31:0] exp, input string req);
      logic [31:0] v;
      bus_read(a, id, v);
      check(v, exp, req);
   endtask

   task automatic irq_chk(input logic [NC-1:0] exp, input string req);
      @(negedge clk);
      check({28'h0, irq}, {28'h0, exp}, req);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   // ---------------- scenarios ----------------
   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      cur_req = "R10";
      read_chk(5'h00, 0, 32'h0, "R10 counter after reset");
      read_chk(5'h08, 1, 32'h0, "R10 control after reset");

      cur_req = "R4";
      bus_write(5'h00, 32'h1234_5678, 0);
      bus_write(5'h04, 32'h0000_AABB, 0);
      read_chk(5'h00, 0, 32'h1234_5678, "R4 counter low");
      read_chk(5'h04, 0, 32'h0000_AABB, "R4 counter high");
      bus_write(5'h00, 32'h1, 0);
      read_chk(5'h04, 2, 32'h0000_AABB, "R4 high half kept");
      bus_write(5'h14, 32'h0000_0077, 3);
      read_chk(5'h10, 3, 32'h0, "R4 comparator low kept");

      cur_req = "R1";
      bus_write(5'h00, 32'h0, 0);
      bus_write(5'h04, 32'h0, 0);
      bus_write(5'h08, 32'h0000_0301, 0);
      idle(39);
      bus_write(5'h08, 32'h0000_0300, 0);
      read_chk(5'h00, 0, 32'd10, "R1 divide by four");
      cur_req = "R2";
      idle(10);
      read_chk(5'h00, 1, 32'd10, "R2 frozen while stopped");

      cur_req = "R3";
      bus_write(5'h00, 32'h50, 0);
      bus_write(5'h08, 32'h0000_FF01, 0);
      bus_write(5'h00, 32'h0, 0);
      bus_write(5'h04, 32'h9, 0);
      read_chk(5'h00, 0, 32'h50, "R3 low write ignored while running");
      read_chk(5'h04, 0, 32'h0, "R3 high write ignored while running");
      bus_write(5'h08, 32'h0, 0);

      cur_req = "R5";
      bus_write(5'h00, 32'h0, 0);
      bus_write(5'h10, 32'd20, 0);
      bus_write(5'h14, 32'h0, 0);
      bus_write(5'h08, 32'h0000_0007, 0);
      idle(40);
      read_chk(5'h0C, 0, 32'h1, "R5 flag set at compare");
      cur_req = "R7";
      irq_chk(4'b0001, "R7 only core0 interrupt");
      cur_req = "R8";
      bus_write(5'h08, 32'h0000_0005, 0);
      bus_write(5'h0C, 32'h0, 0);
      read_chk(5'h0C, 0, 32'h1, "R8 write zero keeps flag");
      bus_write(5'h0C, 32'h1, 0);
      read_chk(5'h0C, 0, 32'h0, "R8 write one clears flag");
      irq_chk(4'b0000, "R7 interrupt drops with flag");

      cur_req = "R6";
      bus_write(5'h08, 32'h0, 0);
      bus_write(5'h00, 32'h0, 0);
      bus_write(5'h10, 32'd5, 1);
      bus_write(5'h18, 32'd10, 1);
      bus_write(5'h08, 32'h0000_000F, 1);
      idle(30);
      bus_write(5'h08, 32'h0000_000E, 1);
      bus_read(5'h10, 1, v);
      check({31'h0, (v > 32'd5) && (v % 10 == 5)}, 32'h1, "R6 comparator advanced by step");
      read_chk(5'h0C, 1, 32'h1, "R6 periodic flag");
      bus_write(5'h0C, 32'h1, 1);
      bus_write(5'h08, 32'h0, 1);

      cur_req = "R9";
      bus_write(5'h08, 32'h0000_070C, 2);
      read_chk(5'h08, 2, 32'h0000_070C, "R9 caller bank merged");
      read_chk(5'h08, 3, 32'h0000_0700, "R9 other bank clear");
      bus_write(5'h08, 32'hFFFF_FFFF, 3);
      read_chk(5'h08, 3, 32'h0000_FF0F, "R9 unused bits zero");
      bus_write(5'h08, 32'h0, 3);
      read_chk(5'h08, 2, 32'h0000_000C, "R9 core2 bank untouched");
      bus_write(5'h0C, 32'h1, 3);

      cur_req = "R11";
      bus_write(5'h1C, 32'hFFFF_FFFF, 0);
      bus_write(5'h19, 32'h0000_0ABC, 0);
      read_chk(5'h1C, 0, 32'h0, "R11 unmapped read");
      read_chk(5'h01, 0, 32'h0, "R11 misaligned read");
      read_chk(5'h18, 0, 32'h0, "R11 step unchanged");

      cur_req = "R10";
      bus_write(5'h08, 32'h0000_000F, 1);
      idle(5);
      @(posedge clk); #1 rst_n = 0;
      idle(2);
      #1 rst_n = 1;
      read_chk(5'h08, 1, 32'h0, "R10 control cleared");
      read_chk(5'h10, 1, 32'h0, "R10 comparator cleared");
      read_chk(5'h18, 1, 32'h0, "R10 step cleared");
      read_chk(5'h00, 0, 32'h0, "R10 counter cleared");
      irq_chk(4'b0000, "R10 interrupts low");

      idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule